// File: doc/BRIEF.md
# Gain Recovery Engine for Automatic Level Control

This block runs the recovery half of a digital automatic level control loop for a programmable input gain stage. It watches a signed sample stream, and while the signal stays quiet it raises the gain code one step at a time toward a programmable reference code. For each step it emits a one-cycle increment request and the new gain code. The attack and limiter path, the gain stage itself and register decoding live elsewhere. The current gain code is fed back in on `gain_i`.

Recovery is gated by two level thresholds. A sample louder than the counter-reset threshold cancels recovery and discards the elapsed wait. Recovery only restarts after a sample falls below the limiter threshold. Each step waits for a programmed number of valid samples. It is then applied on the next zero crossing, or when the zero-crossing timeout runs out. If the timeout is longer than the wait and no crossing arrives, the timeout sets the pace, so the step period varies with signal content.

Top module: `alc_recovery`

## Requirements
- R1: While `rst_ni` is low, `inc_o` is 0, `gain_o` is 0 and recovery is disarmed. After release, the first valid quiet sample only arms recovery and is not counted.
- R2: Level is the magnitude of the two's-complement sample. The most negative code counts as 2^(W-1) and exceeds a reset threshold of 2^(W-1)-1. The most positive code does not exceed it.
- R3: A valid sample whose level is strictly above `reset_thr_i` disarms recovery, clears the wait count and produces no step.
- R4: Recovery re-arms only on a valid sample whose level is strictly below `limit_thr_i`. The arming sample is not counted. Samples at or above the limiter threshold that do not exceed `reset_thr_i` leave the armed state unchanged.
- R5: A 2-bit select value s, for either `wait_sel_i` or `zto_sel_i`, gives a length of BASE_LEN shifted left by s valid samples.
- R6: Armed, below the reference and with no zero crossing, a step happens on the valid sample where the count since the last step reaches the larger of the wait length and the timeout length.
- R7: Once the wait length is reached, a valid sample with `zero_cross_i` high triggers the step at once, before the timeout.
- R8: A step gives `inc_o` high for exactly one cycle, in the cycle after the deciding sample, with `gain_o` equal to that sample's `gain_i` plus one. Outside steps, `gain_o` is `gain_i` delayed by one cycle.
- R9: No step occurs while `gain_i` is at or above `ref_gain_i`, so recovery never drives the gain code past the reference.
- R10: Cycles with `sample_valid_i` low change neither the count nor the armed state, and produce no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed input sample |
| sample_valid_i | input | 1 | Sample strobe |
| zero_cross_i | input | 1 | Zero crossing seen on this sample |
| gain_i | input | GAIN_W | Current gain code |
| limit_thr_i | input | SAMPLE_W | Limiter threshold (re-arm below) |
| reset_thr_i | input | SAMPLE_W | Counter-reset threshold (disarm above) |
| ref_gain_i | input | GAIN_W | Reference gain code, recovery ceiling |
| wait_sel_i | input | 2 | Recovery wait length select |
| zto_sel_i | input | 2 | Zero-crossing timeout select |
| inc_o | output | 1 | Gain increment request, one-cycle pulse |
| gain_o | output | GAIN_W | Updated gain code |

## Verification
A wrong count or a stale armed flag shows only as a step timing error on `inc_o`. A step comes one or more samples early or late, or a missing disarm lets a step through during a loud passage. The error shows at the first step after the fault, at most eight BASE_LEN valid samples later. The bench therefore measures intervals between steps against the period rules for each select pairing. It compares `inc_o` and `gain_o` every cycle with a model, so an off-by-one in the arming sample or the count is seen at the first step.

// File: rtl/alc_rec_pkg.sv
package alc_rec_pkg;

  typedef enum logic [1:0] {
    LEN_X1 = 2'd0,
    LEN_X2 = 2'd1,
    LEN_X4 = 2'd2,
    LEN_X8 = 2'd3
  } len_sel_e;

  typedef struct packed {
    logic valid;
    logic over_reset;
    logic below_limit;
  } lvl_evt_t;

endpackage

// File: rtl/alc_level_det.sv
module alc_level_det
  import alc_rec_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       valid_i,
  input  logic        [SAMPLE_W-1:0] limit_thr_i,
  input  logic        [SAMPLE_W-1:0] reset_thr_i,
  output lvl_evt_t                   evt_o
);

  logic [SAMPLE_W-1:0] mag;

  // most negative code maps to 2^(W-1) as unsigned
  always_comb begin
    if (sample_i[SAMPLE_W-1]) mag = ~sample_i + SAMPLE_W'(1);
    else                      mag = sample_i;
  end

  always_comb begin
    evt_o.valid       = valid_i;
    evt_o.over_reset  = valid_i && (mag > reset_thr_i);
    evt_o.below_limit = valid_i && (mag < limit_thr_i);
  end

  // R2: magnitude never wraps to a small value for a negative input
  always_comb begin
    a_r2_mag_sign : assert (!(sample_i[SAMPLE_W-1]) || mag != '0)
      else $error("a_r2_mag_sign");
  end

endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer
  import alc_rec_pkg::*;
#(
  parameter int unsigned BASE_LEN = 128
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     count_en_i,
  input  logic     clear_i,
  input  logic     zc_i,
  input  len_sel_e wait_sel_i,
  input  len_sel_e zto_sel_i,
  output logic     step_o
);

  localparam int unsigned MAX_LEN = BASE_LEN * 8;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, wait_len, zto_len;

  always_comb begin
    wait_len = CNT_W'(BASE_LEN) << wait_sel_i;
    zto_len  = CNT_W'(BASE_LEN) << zto_sel_i;
    cnt_nxt  = cnt_q + CNT_W'(1);
    step_o   = count_en_i && (cnt_nxt >= wait_len) && (zc_i || cnt_nxt >= zto_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || step_o)   cnt_q <= '0;
    else if (count_en_i)          cnt_q <= cnt_nxt;
  end

  // R6: count never passes the longest selectable length
  a_r6_cnt_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_LEN))
    else $error("a_r6_cnt_bound");

  // R10: idle cycles hold the count
  a_r10_cnt_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !clear_i) |=> $stable(cnt_q))
    else $error("a_r10_cnt_hold");

endmodule

// File: rtl/alc_recovery.sv
module alc_recovery
  import alc_rec_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 7,
  parameter int unsigned BASE_LEN = 128
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sample_valid_i,
  input  logic                       zero_cross_i,
  input  logic        [GAIN_W-1:0]   gain_i,
  input  logic        [SAMPLE_W-1:0] limit_thr_i,
  input  logic        [SAMPLE_W-1:0] reset_thr_i,
  input  logic        [GAIN_W-1:0]   ref_gain_i,
  input  logic        [1:0]          wait_sel_i,
  input  logic        [1:0]          zto_sel_i,
  output logic                       inc_o,
  output logic        [GAIN_W-1:0]   gain_o
);

  lvl_evt_t evt;
  logic     armed_q;
  logic     below_ref, count_en, clear, step;

  alc_level_det #(.SAMPLE_W(SAMPLE_W)) u_level (
    .sample_i    (sample_i),
    .valid_i     (sample_valid_i),
    .limit_thr_i (limit_thr_i),
    .reset_thr_i (reset_thr_i),
    .evt_o       (evt)
  );

  always_comb begin
    below_ref = gain_i < ref_gain_i;
    count_en  = evt.valid && !evt.over_reset && armed_q && below_ref;
    clear     = evt.valid && !count_en;
  end

  alc_step_timer #(.BASE_LEN(BASE_LEN)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (count_en),
    .clear_i    (clear),
    .zc_i       (zero_cross_i),
    .wait_sel_i (len_sel_e'(wait_sel_i)),
    .zto_sel_i  (len_sel_e'(zto_sel_i)),
    .step_o     (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               armed_q <= 1'b0;
    else if (evt.over_reset)   armed_q <= 1'b0;
    else if (evt.below_limit)  armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_o  <= 1'b0;
      gain_o <= '0;
    end else begin
      inc_o  <= step;
      gain_o <= step ? gain_i + GAIN_W'(1) : gain_i;
    end
  end

  // R4: a step only comes from an armed engine
  a_r4_step_armed : assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> armed_q)
    else $error("a_r4_step_armed");

  // R3: a loud sample never yields a step
  a_r3_loud_no_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && evt.over_reset) |=> !inc_o)
    else $error("a_r3_loud_no_step");

  // R8: increment is exactly one code
  a_r8_plus_one : assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> gain_o == $past(gain_i) + GAIN_W'(1))
    else $error("a_r8_plus_one");

  // R9: never beyond reference
  a_r9_ceiling : assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> gain_o <= $past(ref_gain_i))
    else $error("a_r9_ceiling");

  // R10: no strobe, no step
  a_r10_no_valid : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !inc_o)
    else $error("a_r10_no_valid");

endmodule

// File: tb/alc_recovery_tb.sv
module alc_recovery_tb;

  localparam int SW   = 16;
  localparam int GW   = 7;
  localparam int BASE = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic                 valid = 1'b0, zc = 1'b0;
  logic [GW-1:0]        gain_in = '0, ref_gain = '0;
  logic [SW-1:0]        lim_thr = 16'd1000, rst_thr = 16'd4000;
  logic [1:0]           wsel = 2'd0, zsel = 2'd0;
  logic                 inc;
  logic [GW-1:0]        gain_out;

  always #10 clk = ~clk;

  alc_recovery #(.SAMPLE_W(SW), .GAIN_W(GW), .BASE_LEN(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .zero_cross_i(zc), .gain_i(gain_in), .limit_thr_i(lim_thr),
    .reset_thr_i(rst_thr), .ref_gain_i(ref_gain), .wait_sel_i(wsel),
    .zto_sel_i(zsel), .inc_o(inc), .gain_o(gain_out)
  );

  int    n_tests = 0, n_fail = 0;
  string tag = "R1";
  bit    m_armed = 0;
  int    m_cnt = 0;
  bit    exp_inc = 0;
  int    exp_gain = 0;
  int    n = 0, last_inc_n = -1, inc_seen = 0;

  function automatic int len_of(input int sel);
    return BASE << sel;
  endfunction

  function automatic int mag_of(input int s);
    return (s < 0) ? -s : s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model for one driven cycle
  task automatic model(input bit v, input int s, input bit z);
    int a, c;
    exp_inc  = 0;
    exp_gain = int'(gain_in);
    if (v) begin
      a = mag_of(s);
      if (a > int'(rst_thr)) begin
        m_armed = 0; m_cnt = 0;
      end else begin
        if (m_armed && gain_in < ref_gain) begin
          c = m_cnt + 1;
          if (c >= len_of(wsel) && (z || c >= len_of(zsel))) begin
            exp_inc = 1; m_cnt = 0;
          end else m_cnt = c;
        end else m_cnt = 0;
        if (a < int'(lim_thr)) m_armed = 1;
      end
      if (exp_inc) exp_gain = int'(gain_in) + 1;
    end
  endtask

  task automatic cyc(input bit v, input int s, input bit z);
    model(v, s, z);
    valid = v; sample = SW'(s); zc = z;
    @(negedge clk);
    n++;
    chk(inc == exp_inc, {tag, " inc_o"}, int'(inc), int'(exp_inc));
    chk(int'(gain_out) == exp_gain, {tag, " gain_o"}, int'(gain_out), exp_gain);
    if (inc) begin
      last_inc_n = n; inc_seen++;
      gain_in = gain_out;
    end
  endtask

  task automatic run(input int k, input bit v, input int s, input bit z);
    for (int i = 0; i < k; i++) cyc(v, s, z);
  endtask

  // returns interval between next two steps on quiet input
  task automatic period(input bit z, output int p);
    int first;
    last_inc_n = -1;
    while (last_inc_n < 0) cyc(1, 5, z);
    first = last_inc_n; last_inc_n = -1;
    while (last_inc_n < 0) cyc(1, 5, z);
    p = last_inc_n - first;
  endtask

  initial begin
    int p, base_n;
    void'($urandom(32'd2024));
    // R1 reset state
    #5;
    chk(inc == 1'b0, "R1 inc in reset", int'(inc), 0);
    chk(gain_out == '0, "R1 gain in reset", int'(gain_out), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    ref_gain = 7'd120;

    // R1: arming sample not counted -> first step after 1 + period samples
    tag = "R1"; wsel = 2'd1; zsel = 2'd0;
    run(16, 1, 5, 0);
    chk(inc_seen == 0, "R1 no early step", inc_seen, 0);
    cyc(1, 5, 0);
    chk(inc_seen == 1, "R1 first step at 17", inc_seen, 1);

    // R5/R6: wait 16 > timeout 8 -> 16
    tag = "R6"; period(0, p);
    chk(p == 16, "R5 wait-dominated period", p, 16);
    // R6: wait 8 < timeout 32, no crossing -> 32
    wsel = 2'd0; zsel = 2'd2; run(40, 1, 5, 0);
    period(0, p);
    chk(p == 32, "R6 timeout-dominated period", p, 32);
    // R7: crossing every sample -> wait length
    tag = "R7"; period(1, p);
    chk(p == 8, "R7 crossing period", p, 8);

    // R3: loud sample discards count
    tag = "R3"; wsel = 2'd1; zsel = 2'd0;
    run(40, 1, 5, 0);
    last_inc_n = -1; while (last_inc_n < 0) cyc(1, 5, 0);
    run(10, 1, 5, 0);
    cyc(1, -5000, 0); base_n = n; last_inc_n = -1;
    while (last_inc_n < 0) cyc(1, 5, 0);
    chk(last_inc_n - base_n == 17, "R3 count discarded", last_inc_n - base_n, 17);

    // R4: mid-level samples do not re-arm
    tag = "R4"; cyc(1, 5000, 0); inc_seen = 0;
    run(40, 1, 2000, 0);
    chk(inc_seen == 0, "R4 no rearm mid-level", inc_seen, 0);
    base_n = n; last_inc_n = -1;
    while (last_inc_n < 0) cyc(1, 5, 0);
    chk(last_inc_n - base_n == 17, "R4 rearm below limit", last_inc_n - base_n, 17);

    // R10: invalid loud cycles ignored
    tag = "R10"; run(5, 1, 5, 0); inc_seen = 0;
    run(30, 0, -9000, 0);
    chk(inc_seen == 0, "R10 invalid no step", inc_seen, 0);
    base_n = n; last_inc_n = -1;
    while (last_inc_n < 0) cyc(1, 5, 0);
    chk(last_inc_n - base_n == 11, "R10 count kept", last_inc_n - base_n, 11);

    // R2: full-scale magnitudes
    tag = "R2"; rst_thr = 16'd32767; inc_seen = 0;
    for (int i = 0; i < 6; i++) begin cyc(1, -32768, 0); run(9, 1, 5, 0); end
    chk(inc_seen == 0, "R2 most negative disarms", inc_seen, 0);
    run(20, 1, 5, 0); inc_seen = 0;
    for (int i = 0; i < 6; i++) begin cyc(1, 32767, 0); run(9, 1, 5, 0); end
    chk(inc_seen >= 3, "R2 most positive not over", inc_seen, 3);
    rst_thr = 16'd4000;

    // R9: ceiling
    tag = "R9"; ref_gain = gain_in + 7'd2; inc_seen = 0;
    run(100, 1, 5, 1);
    chk(inc_seen == 2, "R9 stops at reference", inc_seen, 2);
    chk(gain_out == ref_gain, "R9 gain at reference", int'(gain_out), int'(ref_gain));

    // R8 and others: constrained random against model
    tag = "R8";
    for (int i = 0; i < 6000; i++) begin
      int r, s;
      bit v;
      if (i % 500 == 0) begin
        wsel = 2'($urandom % 4); zsel = 2'($urandom % 4);
        gain_in = 7'($urandom % 40); ref_gain = gain_in + 7'($urandom % 20);
      end
      r = int'($urandom % 20);
      if (r < 15)      s = int'($urandom % 999) - 499;
      else if (r < 18) s = 1000 + int'($urandom % 3000);
      else             s = -(4001 + int'($urandom % 20000));
      v = ($urandom % 5) != 0;
      cyc(v, s, ($urandom % 6) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule